// File: doc/BRIEF.md
# UART Modem Control and Diagnostic Loopback

This block is the modem-control side of one serial channel. A small register port loads a control byte that drives four modem handshake outputs: two active-low lines for data-terminal-ready and request-to-send, and two general outputs whose pad level follows the control bit. The four active-low status inputs (clear-to-send, data-set-ready, data-carrier-detect and ring indicator) pass through a two-stage synchronizer. The block then derives sticky change flags from them and raises a modem-status interrupt when those flags are enabled.

Setting the loopback bit isolates the channel for self-test. The serial output and all four modem outputs go to their idle high level, and the external serial and status inputs are ignored. The transmit bit is routed straight to the receive side, and each control bit stands in for one status line, so the change flags and their interrupt are driven from the control byte. A separate, lower-priority handshake-change interrupt latches whenever the clear-to-send line or the request-to-send pad goes from low to high. It stays pending until the identification register is read while it is the interrupt being reported. An interrupt-select input decides whether control bit 3 can float the interrupt pad.

Top module: `uart_modem_ctl`

## Requirements
- R1: Outside loopback, control bit 0 set drives `dtr_n_o` low and clear drives it high; control bit 1 does the same for `rts_n_o`. The pads update one cycle after the write.
- R2: Outside loopback, `out1_o` follows control bit 2 and `out2_o` follows control bit 3 (1 gives high, 0 gives low).
- R3: With `int_sel_n_i` low, `irq_oe_o` equals control bit 3. With `int_sel_n_i` high, `irq_oe_o` is 1 whatever bit 3 holds. `irq_o` is high whenever any enabled interrupt is pending.
- R4: Control bit 4 set enables loopback. `sout_o`, `dtr_n_o`, `rts_n_o`, `out1_o` and `out2_o` are all high, and `sin_i` and the four status pads have no effect.
- R5: In loopback, `rx_bit_o` equals `tx_bit_i`. The status lines read as follows: CTS = control bit 1, DSR = control bit 0, RI = control bit 2 and DCD = control bit 3.
- R6: Status register (address 1) bits 4..7 show CTS, DSR, RI and DCD active-high. Outside loopback they are the inverted pads after a two-flip-flop synchronizer, visible two clocks after a pad change.
- R7: Status bits 0..3 are sticky change flags. Bit 0 marks a CTS change, bit 1 a DSR change, bit 2 RI going from active to inactive only, and bit 3 a DCD change. Each flag is set one clock after its line changes. A status read clears all four, except a flag set by a change in the same cycle, which is kept.
- R8: Enable register (address 2) bit 0 gates the modem-status interrupt. The interrupt is pending when any change flag is set and bit 0 is 1. This holds in loopback with control-bit sources.
- R9: The handshake-change flag is set one cycle after the CTS line (active-low level) or the `rts_n_o` pad rises. When enable bit 1 is set, it reports identification code 6'b100000.
- R10: The identification register (address 3, bits 5:0) reports 6'b000000 for a modem-status interrupt, which wins over the handshake change. It reports 6'b000001 when nothing is pending.
- R11: Reading the identification register clears the handshake flag only when that read returned 6'b100000. A rising edge in the same cycle keeps the flag set.
- R12: Address 0 holds control bits 4:0 (upper bits read 0). Address 2 holds enable bits 1:0. Writes to addresses 1 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (drives read side effects) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| tx_bit_i | input | 1 | Serial bit from the transmitter |
| rx_bit_o | output | 1 | Serial bit to the receiver |
| sin_i | input | 1 | Serial input pad |
| sout_o | output | 1 | Serial output pad |
| cts_n_i | input | 1 | Clear-to-send pad, active low |
| dsr_n_i | input | 1 | Data-set-ready pad, active low |
| dcd_n_i | input | 1 | Carrier-detect pad, active low |
| ri_n_i | input | 1 | Ring-indicator pad, active low |
| dtr_n_o | output | 1 | Data-terminal-ready pad, active low |
| rts_n_o | output | 1 | Request-to-send pad, active low |
| out1_o | output | 1 | General output 1 pad |
| out2_o | output | 1 | General output 2 pad |
| int_sel_n_i | input | 1 | Interrupt-select strap |
| irq_o | output | 1 | Interrupt level |
| irq_oe_o | output | 1 | Interrupt pad drive enable (0 = high impedance) |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a status read and a new change flag. The bench times a pad change so that the flag is set on the same edge that a status read clears the register, and expects the flag to survive that read and to vanish on the next one. The second pair is an identification read that returns the handshake code and a fresh clear-to-send rising edge on the same edge. The handshake code must still be reported on the following read, and only that later read may clear it.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int REG_DW = 8;
  localparam int REG_AW = 2;
  localparam int CTL_W  = 5;
  localparam int IEN_W  = 2;
  localparam int ID_W   = 6;
  localparam int NLINES = 4;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [REG_AW-1:0] {
    ADR_CTL   = 2'd0,
    ADR_STAT  = 2'd1,
    ADR_IEN   = 2'd2,
    ADR_IDENT = 2'd3
  } reg_addr_e;

  localparam logic [ID_W-1:0] ID_NONE   = 6'b000001;
  localparam logic [ID_W-1:0] ID_MSTAT  = 6'b000000;
  localparam logic [ID_W-1:0] ID_HSHAKE = 6'b100000;

  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_OUT1 = 2;
  localparam int CB_OUT2 = 3;
  localparam int CB_LOOP = 4;

  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  localparam int IE_MSTAT  = 0;
  localparam int IE_HSHAKE = 1;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int              WIDTH   = 5,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d[0] = d_i[g];
      for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
      else        chain_q <= chain_d;
    end

    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic [REG_DW-1:0] stat_i,
  input  logic [ID_W-1:0]   ident_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [IEN_W-1:0]  ien_o,
  output logic              rd_stat_o,
  output logic              rd_ident_o
);
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic [IEN_W-1:0] ien_q, ien_d;
  logic             ctl_we, ien_we;

  always_comb begin
    ctl_we = wr_i && (addr_i == ADR_CTL);
    ien_we = wr_i && (addr_i == ADR_IEN);
    ctl_d  = wdata_i[CTL_W-1:0];
    ien_d  = wdata_i[IEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q <= ien_d;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_CTL:   rdata_o[CTL_W-1:0] = ctl_q;
      ADR_STAT:  rdata_o            = stat_i;
      ADR_IEN:   rdata_o[IEN_W-1:0] = ien_q;
      ADR_IDENT: rdata_o[ID_W-1:0]  = ident_i;
      default:   rdata_o            = '0;
    endcase
  end

  assign ctl_o      = ctl_q;
  assign ien_o      = ien_q;
  assign rd_stat_o  = rd_i && (addr_i == ADR_STAT);
  assign rd_ident_o = rd_i && (addr_i == ADR_IDENT);

  // R12: a control write lands one cycle later; no write leaves it unchanged
  a_r12_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_q == $past(wdata_i[CTL_W-1:0])));
  a_r12_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_q));
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pin_act_i,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic [IEN_W-1:0]  ien_i,
  input  logic              rts_pad_i,
  input  logic              rd_stat_i,
  input  logic              rd_ident_i,
  output logic [REG_DW-1:0] stat_o,
  output logic [ID_W-1:0]   ident_o,
  output logic              irq_o
);
  logic [NLINES-1:0] line_cur, line_q;
  logic [NLINES-1:0] chg_set;
  logic [NLINES-1:0] delta_q, delta_d;
  logic              rts_prev_q;
  logic              hs_q, hs_d;
  logic              hs_rise, hs_clr;
  logic              msi_pend, hs_rep;
  logic              loop;

  assign loop = ctl_i[CB_LOOP];

  // Loopback source selection: each line has its own control-bit stand-in
  always_comb begin
    line_cur[LN_CTS] = loop ? ctl_i[CB_RTS]  : pin_act_i[LN_CTS];
    line_cur[LN_DSR] = loop ? ctl_i[CB_DTR]  : pin_act_i[LN_DSR];
    line_cur[LN_RI]  = loop ? ctl_i[CB_OUT1] : pin_act_i[LN_RI];
    line_cur[LN_DCD] = loop ? ctl_i[CB_OUT2] : pin_act_i[LN_DCD];
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_chg
    if (i == LN_RI) begin : g_trail
      assign chg_set[i] = line_q[i] & ~line_cur[i];
    end else begin : g_any
      assign chg_set[i] = line_q[i] ^ line_cur[i];
    end
  end

  always_comb begin
    delta_d  = (rd_stat_i ? '0 : delta_q) | chg_set;
    hs_rise  = (line_q[LN_CTS] & ~line_cur[LN_CTS]) | (~rts_prev_q & rts_pad_i);
    msi_pend = (|delta_q) & ien_i[IE_MSTAT];
    hs_rep   = hs_q & ien_i[IE_HSHAKE];
    if (msi_pend)    ident_o = ID_MSTAT;
    else if (hs_rep) ident_o = ID_HSHAKE;
    else             ident_o = ID_NONE;
    hs_clr   = rd_ident_i && (ident_o == ID_HSHAKE);
    hs_d     = (hs_q & ~hs_clr) | hs_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q     <= '0;
      delta_q    <= '0;
      rts_prev_q <= 1'b1;
      hs_q       <= 1'b0;
    end else begin
      line_q     <= line_cur;
      delta_q    <= delta_d;
      rts_prev_q <= rts_pad_i;
      hs_q       <= hs_d;
    end
  end

  assign stat_o = {line_cur, delta_q};
  assign irq_o  = msi_pend | hs_rep;

  // R7: flags persist until a status read
  a_r7_delta_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat_i |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
  // R7: a read with no concurrent change empties the flags
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_i && (chg_set == '0)) |=> (delta_q == '0));
  // R7: ring indicator only flags its trailing edge
  a_r7_ri_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stat_i && !delta_q[LN_RI] && !line_q[LN_RI]) |=> !delta_q[LN_RI]);
  // R9: a rising handshake line latches the flag
  a_r9_hs_set: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> hs_q);
  // R11: reporting read with no new edge clears the flag
  a_r11_hs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_clr && !hs_rise) |=> !hs_q);
  // R10: modem status outranks the handshake code
  a_r10_priority: assert property (@(posedge clk) disable iff (!rst_n)
    ((|delta_q) && ien_i[IE_MSTAT]) |-> (ident_o != ID_HSHAKE));
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic              tx_bit_i,
  output logic              rx_bit_o,
  input  logic              sin_i,
  output logic              sout_o,
  input  logic              cts_n_i,
  input  logic              dsr_n_i,
  input  logic              dcd_n_i,
  input  logic              ri_n_i,
  output logic              dtr_n_o,
  output logic              rts_n_o,
  output logic              out1_o,
  output logic              out2_o,
  input  logic              int_sel_n_i,
  output logic              irq_o,
  output logic              irq_oe_o
);
  localparam int NSYNC  = NLINES + 1;
  localparam int SIN_IX = NLINES;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NSYNC-1:0]  pad_raw, pad_sync;
  logic [NLINES-1:0] pin_act;
  logic [CTL_W-1:0]  ctl;
  logic [IEN_W-1:0]  ien;
  logic [REG_DW-1:0] stat;
  logic [ID_W-1:0]   ident;
  logic              rd_stat, rd_ident;
  logic              loop;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    pad_raw[LN_CTS] = cts_n_i;
    pad_raw[LN_DSR] = dsr_n_i;
    pad_raw[LN_RI]  = ri_n_i;
    pad_raw[LN_DCD] = dcd_n_i;
    pad_raw[SIN_IX] = sin_i;
  end

  mdm_sync #(
    .WIDTH  (NSYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NSYNC{1'b1}})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d_i  (pad_raw),
    .q_o  (pad_sync)
  );

  assign pin_act = ~pad_sync[NLINES-1:0];

  mdm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .stat_i    (stat),
    .ident_i   (ident),
    .rdata_o   (reg_rdata_o),
    .ctl_o     (ctl),
    .ien_o     (ien),
    .rd_stat_o (rd_stat),
    .rd_ident_o(rd_ident)
  );

  assign loop = ctl[CB_LOOP];

  always_comb begin
    dtr_n_o  = loop | ~ctl[CB_DTR];
    rts_n_o  = loop | ~ctl[CB_RTS];
    out1_o   = loop |  ctl[CB_OUT1];
    out2_o   = loop |  ctl[CB_OUT2];
    sout_o   = loop |  tx_bit_i;
    rx_bit_o = loop ? tx_bit_i : pad_sync[SIN_IX];
    irq_oe_o = int_sel_n_i | ctl[CB_OUT2];
  end

  mdm_status u_status (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pin_act_i (pin_act),
    .ctl_i     (ctl),
    .ien_i     (ien),
    .rts_pad_i (rts_n_o),
    .rd_stat_i (rd_stat),
    .rd_ident_i(rd_ident),
    .stat_o    (stat),
    .ident_o   (ident),
    .irq_o     (irq_o)
  );

  // R1: handshake pads follow a non-loopback control write
  a_r1_hs_pads: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_wr_i && reg_addr_i == ADR_CTL && !reg_wdata_i[CB_LOOP]) |=>
      (dtr_n_o == !$past(reg_wdata_i[CB_DTR]) && rts_n_o == !$past(reg_wdata_i[CB_RTS])));
  // R2: general outputs follow a non-loopback control write
  a_r2_out_pads: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_wr_i && reg_addr_i == ADR_CTL && !reg_wdata_i[CB_LOOP]) |=>
      (out1_o == $past(reg_wdata_i[CB_OUT1]) && out2_o == $past(reg_wdata_i[CB_OUT2])));
  // R3: strap low and bit 3 clear floats the interrupt pad
  a_r3_irq_float: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!int_sel_n_i && !ctl[CB_OUT2]) |-> !irq_oe_o);
  // R4: a loopback write idles every output pad
  a_r4_loop_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_wr_i && reg_addr_i == ADR_CTL && reg_wdata_i[CB_LOOP]) |=>
      (sout_o && dtr_n_o && rts_n_o && out1_o && out2_o));
  // R5: in loopback the receive bit is the transmit bit
  a_r5_loop_rx: assert property (@(posedge clk) disable iff (!rst_int_n)
    loop |-> (rx_bit_o == tx_bit_i));
endmodule

// File: tb/uart_modem_ctl_tb.sv
`timescale 1ns/1ps
module uart_modem_ctl_tb;
  logic       clk;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       tx_bit, rx_bit, sin, sout;
  logic       cts_n, dsr_n, dcd_n, ri_n;
  logic       dtr_n, rts_n, out1, out2;
  logic       int_sel_n, irq, irq_oe;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] rv;

  uart_modem_ctl u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_bit_i(tx_bit), .rx_bit_o(rx_bit), .sin_i(sin), .sout_o(sout),
    .cts_n_i(cts_n), .dsr_n_i(dsr_n), .dcd_n_i(dcd_n), .ri_n_i(ri_n),
    .dtr_n_o(dtr_n), .rts_n_o(rts_n), .out1_o(out1), .out2_o(out2),
    .int_sel_n_i(int_sel_n), .irq_o(irq), .irq_oe_o(irq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at a negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic flush();
    tick(4);
    wr(2, 8'h02);
    rd(1, rv); rd(1, rv);
    rd(3, rv); rd(3, rv);
    wr(2, 8'h00);
  endtask

  task automatic t_reset();
    rd(0, rv); chk("R12 reset control", rv, 8'h00);
    rd(1, rv); chk("R6 reset status", rv, 8'h00);
    rd(2, rv); chk("R12 reset enable", rv, 8'h00);
    rd(3, rv); chk("R10 reset ident none", rv, 8'h01);
    chk("R1 reset pads", {4'h0, dtr_n, rts_n, out1, out2}, 8'h0C);
    chk("R3 reset irq", {7'h0, irq}, 8'h00);
  endtask

  task automatic t_pads();
    wr(0, 8'h03);
    chk("R1 dtr/rts active", {6'h0, dtr_n, rts_n}, 8'h00);
    chk("R2 outs low", {6'h0, out1, out2}, 8'h00);
    wr(0, 8'h0C);
    chk("R1 dtr/rts idle", {6'h0, dtr_n, rts_n}, 8'h03);
    chk("R2 outs high", {6'h0, out1, out2}, 8'h03);
    tx_bit = 1'b0; sin = 1'b1; tick(3);
    chk("R4 normal sout/rx", {6'h0, sout, rx_bit}, 8'h01);
    wr(0, 8'h00);
    flush();
  endtask

  task automatic t_intpad();
    int_sel_n = 1'b0;
    wr(0, 8'h00); #1 chk("R3 strap low bit3 clear floats", {7'h0, irq_oe}, 8'h00);
    wr(0, 8'h08); #1 chk("R3 strap low bit3 set drives", {7'h0, irq_oe}, 8'h01);
    int_sel_n = 1'b1;
    wr(0, 8'h00); #1 chk("R3 strap high always drives", {7'h0, irq_oe}, 8'h01);
    flush();
  endtask

  task automatic t_loop();
    cts_n = 0; dsr_n = 0; dcd_n = 0; ri_n = 0;
    flush();
    rd(1, rv); chk("R6 all pads active", rv, 8'hF0);
    wr(2, 8'h01);
    tx_bit = 1'b0; sin = 1'b1;
    wr(0, 8'h10);
    chk("R4 loop idles pads", {3'h0, sout, dtr_n, rts_n, out1, out2}, 8'h1F);
    chk("R5 loop rx=tx low", {7'h0, rx_bit}, 8'h00);
    tx_bit = 1'b1; sin = 1'b0; #1
    chk("R5 loop rx=tx high", {7'h0, rx_bit}, 8'h01);
    tick(1);
    rd(3, rv); chk("R8 loop msi ident", rv, 8'h00);
    rd(1, rv); chk("R4 R7 pads ignored, all deltas", rv, 8'h0F);
    wr(0, 8'h13);
    chk("R4 loop keeps dtr/rts idle", {6'h0, dtr_n, rts_n}, 8'h03);
    tick(1);
    rd(1, rv); chk("R5 dtr->dsr rts->cts", rv, 8'h33);
    wr(0, 8'h1D);
    tick(1);
    rd(1, rv); chk("R5 out1->ri out2->dcd", rv, 8'hE9);
    wr(0, 8'h00);
    cts_n = 1; dsr_n = 1; dcd_n = 1; ri_n = 1;
    flush();
  endtask

  task automatic t_sync();
    cts_n = 1'b0;
    tick(1);
    rd(1, rv); chk("R6 sync latency one clock", rv, 8'h00);
    rd(1, rv); chk("R6 visible after two clocks", rv, 8'h10);
    rd(1, rv); chk("R7 flag kept on collision read", rv, 8'h11);
    rd(1, rv); chk("R7 cleared on next read", rv, 8'h10);
    ri_n = 1'b0; tick(4);
    rd(1, rv); chk("R7 ri leading edge no flag", rv, 8'h50);
    ri_n = 1'b1; tick(4);
    rd(1, rv); chk("R7 ri trailing edge flag", rv, 8'h14);
  endtask

  task automatic t_hs();
    wr(2, 8'h02);
    wr(0, 8'h02); wr(0, 8'h00);
    tick(1);
    chk("R9 rts rise raises irq", {7'h0, irq}, 8'h01);
    cts_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(3, rv); chk("R9 hs code", rv, 8'h20);
    rd(3, rv); chk("R11 cts rise during clearing read keeps flag", rv, 8'h20);
    rd(3, rv); chk("R11 cleared after reporting read", rv, 8'h01);
    chk("R3 irq low when idle", {7'h0, irq}, 8'h00);
    flush();
  endtask

  task automatic t_prio();
    wr(2, 8'h01);
    dcd_n = 1'b0; tick(4);
    rd(3, rv); chk("R8 msi enabled", rv, 8'h00);
    chk("R3 irq high", {7'h0, irq}, 8'h01);
    wr(2, 8'h00);
    rd(3, rv); chk("R8 msi gated off", rv, 8'h01);
    chk("R3 irq low gated", {7'h0, irq}, 8'h00);
    wr(2, 8'h03);
    wr(0, 8'h02); wr(0, 8'h00); tick(1);
    rd(3, rv); chk("R10 msi beats hs", rv, 8'h00);
    rd(1, rv); chk("R7 dcd flag", rv, 8'h88);
    rd(3, rv); chk("R11 hs kept by msi read", rv, 8'h20);
    rd(3, rv); chk("R10 none after clear", rv, 8'h01);
    dcd_n = 1'b1;
    flush();
  endtask

  task automatic t_map();
    wr(1, 8'hFF);
    rd(1, rv); chk("R12 status write ignored", rv, 8'h00);
    wr(3, 8'hFF);
    rd(3, rv); chk("R12 ident write ignored", rv, 8'h01);
    wr(2, 8'hFF);
    rd(2, rv); chk("R12 enable width", rv, 8'h03);
    wr(2, 8'h00);
    wr(0, 8'hFF);
    rd(0, rv); chk("R12 control width", rv, 8'h1F);
    wr(0, 8'h00);
    flush();
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    tx_bit = 1; sin = 1; cts_n = 1; dsr_n = 1; dcd_n = 1; ri_n = 1;
    int_sel_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tick(4);
    t_reset();
    t_pads();
    t_intpad();
    t_loop();
    t_sync();
    t_hs();
    t_prio();
    t_map();
    summary();
  end
endmodule